// File: doc/BRIEF.md
# Sleep-Mode Interrupt Recorder

This block sits between a bank of external interrupt lines and a parent interrupt controller. While the parent is powered down or cannot see its inputs, the block watches every line and latches events into a per-line status bit. The event is a polarity-matched edge or, for level-configured lines, an active level. Recording goes on whether or not the block is enabled and whether or not a line is masked.

On resume, software issues a flush command. Every recorded, unmasked line then produces a single-cycle active pulse on its own output toward the parent, and its status is cleared. Outside a flush, each output rests at the inactive level of its polarity.

Configuration goes through a small 32-bit register bus. Mask, sensitivity and polarity each have a write-one-to-set address and a write-one-to-clear address. Status is cleared through acknowledge words. A control word carries the enable, edge-only and flush bits.

Top module: `irq_sleep_recorder`

## Requirements
- R1: Line n occupies bit (n mod 32) of the word at base + 4*(n div 32). The bases are: acknowledge/status 0x040, mask set 0x0C0 and clear 0x100, sensitivity set 0x180 and clear 0x1C0, polarity set 0x240 and clear 0x280, control 0x300. Bits above the last line read as 0.
- R2: A 1 written to a set or clear address changes only that line's bit. A 0 leaves it unchanged. A read of either the set or the clear address returns the current register value.
- R3: After reset, every line is masked (mask bit 1), edge-sensitive (sensitivity bit 0) and active-high (polarity bit 1). Status and control read as 0, and each output rests at its inactive level (0 for active-high).
- R4: Inputs pass through a two-flop synchronizer. An edge-configured line records an edge between consecutive synchronized samples: rising when polarity is 1, falling when polarity is 0. The status bit becomes readable after the third rising clock edge following the input change.
- R5: A level-configured line (sensitivity 1) records while its synchronized input is at the active level: high for polarity 1, low for polarity 0.
- R6: Recording happens whether the enable bit is 0 or 1 and whether the line is masked or not.
- R7: While the edge-only bit is 1, level-configured lines record nothing. Edge-configured lines still record.
- R8: Writing 1 to a line's acknowledge bit clears its status. A new event arriving in the same cycle wins, and the status stays set.
- R9: A control write with both the flush bit and the enable bit set has two effects on the next edge. Each recorded, unmasked line drives its output to the active level for exactly one cycle: 1 for polarity 1, 0 for polarity 0. Its status is also cleared. Masked lines give no pulse and keep their status.
- R10: A control write with the flush bit set but the enable bit clear replays nothing and clears no status. The flush bit always reads back as 0.
- R11: Control bit 0 is enable, bit 1 is edge-only and bit 2 is flush. Bits 0 and 1 hold the last written value and read back at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_LINES | Asynchronous external interrupt lines |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | N_LINES | Per-line replay outputs to the parent controller |

## Verification
The bench builds the block with 40 lines, so the line space spans one full word and a second word holding only eight lines. This brings within reach the word-index arithmetic of the address map, the zero reads above the last line, and replay on a line that sits in the second word. The vector table walks edge and level detection under both polarities, with edge-only mode on and off. Directed tests then cover the synchronizer latency, acknowledge, and flush with and without enable across masked and active-low lines.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_ACK  = 12'h040;
  localparam logic [REG_AW-1:0] OFS_MSET = 12'h0C0;
  localparam logic [REG_AW-1:0] OFS_MCLR = 12'h100;
  localparam logic [REG_AW-1:0] OFS_SSET = 12'h180;
  localparam logic [REG_AW-1:0] OFS_SCLR = 12'h1C0;
  localparam logic [REG_AW-1:0] OFS_PSET = 12'h240;
  localparam logic [REG_AW-1:0] OFS_PCLR = 12'h280;
  localparam logic [REG_AW-1:0] OFS_CTRL = 12'h300;

  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_EDGE  = 1;
  localparam int unsigned CTL_FLUSH = 2;

  function automatic int unsigned words_for(int unsigned n);
    return (n + 31) / 32;
  endfunction
endpackage

// File: rtl/irq_rec_sync.sv
module irq_rec_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_rec_regs.sv
module irq_rec_regs
  import irq_rec_pkg::*;
#(
  parameter int unsigned N_LINES = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [N_LINES-1:0] status_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] sens_o,
  output logic [N_LINES-1:0] pol_o,
  output logic              edge_only_o,
  output logic [N_LINES-1:0] ack_o,
  output logic              flush_go_o
);
  localparam int unsigned WORDS = words_for(N_LINES);
  localparam int unsigned PAD   = WORDS * 32;

  logic wr;
  logic [N_LINES-1:0] mset, mclr, sset, sclr, pset, pclr;
  logic [N_LINES-1:0] mask_q, sens_q, pol_q;
  logic en_q, edge_q;
  logic ctrl_wr;

  assign wr      = bus_req_i & bus_we_i;
  assign ctrl_wr = wr && (bus_addr_i == OFS_CTRL);

  for (genvar n = 0; n < N_LINES; n++) begin : g_dec
    localparam logic [REG_AW-1:0] WOFS = REG_AW'(4 * (n / 32));
    localparam int unsigned       BIT  = n % 32;
    assign mset[n]  = wr && (bus_addr_i == OFS_MSET + WOFS) && bus_wdata_i[BIT];
    assign mclr[n]  = wr && (bus_addr_i == OFS_MCLR + WOFS) && bus_wdata_i[BIT];
    assign sset[n]  = wr && (bus_addr_i == OFS_SSET + WOFS) && bus_wdata_i[BIT];
    assign sclr[n]  = wr && (bus_addr_i == OFS_SCLR + WOFS) && bus_wdata_i[BIT];
    assign pset[n]  = wr && (bus_addr_i == OFS_PSET + WOFS) && bus_wdata_i[BIT];
    assign pclr[n]  = wr && (bus_addr_i == OFS_PCLR + WOFS) && bus_wdata_i[BIT];
    assign ack_o[n] = wr && (bus_addr_i == OFS_ACK  + WOFS) && bus_wdata_i[BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      sens_q <= '0;
      pol_q  <= '1;
      en_q   <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      mask_q <= (mask_q | mset) & ~mclr;
      sens_q <= (sens_q | sset) & ~sclr;
      pol_q  <= (pol_q  | pset) & ~pclr;
      if (ctrl_wr) begin
        en_q   <= bus_wdata_i[CTL_EN];
        edge_q <= bus_wdata_i[CTL_EDGE];
      end
    end
  end

  // flush acts only when the same write keeps enable set
  assign flush_go_o  = ctrl_wr & bus_wdata_i[CTL_FLUSH] & bus_wdata_i[CTL_EN];
  assign mask_o      = mask_q;
  assign sens_o      = sens_q;
  assign pol_o       = pol_q;
  assign edge_only_o = edge_q;

  logic [PAD-1:0] stat_pad, mask_pad, sens_pad, pol_pad;
  assign stat_pad = PAD'(status_i);
  assign mask_pad = PAD'(mask_q);
  assign sens_pad = PAD'(sens_q);
  assign pol_pad  = PAD'(pol_q);

  always_comb begin
    bus_rdata_o = '0;
    for (int w = 0; w < int'(WORDS); w++) begin
      if (bus_addr_i == OFS_ACK + REG_AW'(4 * w))
        bus_rdata_o = stat_pad[w*32 +: 32];
      if (bus_addr_i == OFS_MSET + REG_AW'(4 * w) || bus_addr_i == OFS_MCLR + REG_AW'(4 * w))
        bus_rdata_o = mask_pad[w*32 +: 32];
      if (bus_addr_i == OFS_SSET + REG_AW'(4 * w) || bus_addr_i == OFS_SCLR + REG_AW'(4 * w))
        bus_rdata_o = sens_pad[w*32 +: 32];
      if (bus_addr_i == OFS_PSET + REG_AW'(4 * w) || bus_addr_i == OFS_PCLR + REG_AW'(4 * w))
        bus_rdata_o = pol_pad[w*32 +: 32];
    end
    if (bus_addr_i == OFS_CTRL)
      bus_rdata_o = {29'd0, 1'b0, edge_q, en_q};
  end

  AST_MASK_W1_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(mset | mclr)) == '0)); // R2

  AST_POL_W1_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pol_q ^ $past(pol_q)) & ~$past(pset | pclr)) == '0)); // R2
endmodule

// File: rtl/irq_rec_bank.sv
module irq_rec_bank #(
  parameter int unsigned N_LINES = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] sync_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] sens_i,
  input  logic [N_LINES-1:0] pol_i,
  input  logic               edge_only_i,
  input  logic [N_LINES-1:0] ack_i,
  input  logic               flush_go_i,
  output logic [N_LINES-1:0] status_o,
  output logic [N_LINES-1:0] irq_o
);
  logic [N_LINES-1:0] prev_q, status_q, pulse_q;
  logic [N_LINES-1:0] rise, fall, edge_ev, level_ev, ev, replay;

  assign rise     = sync_i & ~prev_q;
  assign fall     = ~sync_i & prev_q;
  assign edge_ev  = (pol_i & rise) | (~pol_i & fall);
  assign level_ev = ~(sync_i ^ pol_i);
  assign ev       = (~sens_i & edge_ev) | (sens_i & level_ev & {N_LINES{~edge_only_i}});
  assign replay   = {N_LINES{flush_go_i}} & status_q & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
      pulse_q  <= '0;
    end else begin
      prev_q   <= sync_i;
      status_q <= (status_q & ~ack_i & ~replay) | ev;
      pulse_q  <= replay;
    end
  end

  assign status_o = status_q;
  assign irq_o    = pulse_q ^ ~pol_i;

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(ack_i & ~ev)) == '0)); // R8

  AST_EDGE_ONLY_NO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(sens_i & {N_LINES{edge_only_i}})) == '0)); // R7

  AST_PULSE_NEEDS_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q != '0) |-> $past(flush_go_i)); // R9

  AST_MASKED_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pulse_q & $past(mask_i)) == '0)); // R9

  AST_MASKED_KEEPS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~status_q & $past(status_q & mask_i & ~ack_i)) == '0)); // R9
endmodule

// File: rtl/irq_sleep_recorder.sv
module irq_sleep_recorder
  import irq_rec_pkg::*;
#(
  parameter int unsigned N_LINES = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [11:0]        bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic [N_LINES-1:0] irq_o
);
  logic [N_LINES-1:0] sync, mask, sens, pol, ack, status;
  logic edge_only, flush_go;

  irq_rec_sync #(.WIDTH(N_LINES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (sync)
  );

  irq_rec_regs #(.N_LINES(N_LINES)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .status_i   (status),
    .mask_o     (mask),
    .sens_o     (sens),
    .pol_o      (pol),
    .edge_only_o(edge_only),
    .ack_o      (ack),
    .flush_go_o (flush_go)
  );

  irq_rec_bank #(.N_LINES(N_LINES)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync),
    .mask_i     (mask),
    .sens_i     (sens),
    .pol_i      (pol),
    .edge_only_i(edge_only),
    .ack_i      (ack),
    .flush_go_i (flush_go),
    .status_o   (status),
    .irq_o      (irq_o)
  );

  AST_IDLE_WITHOUT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(flush_go) |-> (irq_o == ~pol)); // R9
endmodule

// File: tb/test_irq_sleep_recorder.sv
module test_irq_sleep_recorder;
  localparam int NL = 40;
  localparam logic [11:0] A_ACK = 12'h040, A_MSET = 12'h0C0, A_MCLR = 12'h100,
                          A_SSET = 12'h180, A_SCLR = 12'h1C0, A_PSET = 12'h240,
                          A_PCLR = 12'h280, A_CTRL = 12'h300;

  // {line[5:0], sens, pol, edge_only, v0, v1, expected}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {6'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {6'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {6'd35, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {6'd35, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {6'd39, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {6'd39, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {6'd39, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {6'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {6'd20, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {6'd20, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] irq_d = '0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NL-1:0] irq_q;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_sleep_recorder #(.N_LINES(NL)) i_irq_sleep_recorder (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_d),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq_q)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_req = 1'b0;
  endtask

  function automatic logic [11:0] wofs(input int ln);
    return 12'(4 * (ln / 32));
  endfunction

  function automatic logic [31:0] bitw(input int ln);
    return 32'(1) << (ln % 32);
  endfunction

  task automatic ack_all();
    wr(A_ACK, 32'hFFFF_FFFF);
    wr(A_ACK + 12'd4, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state, R1 word layout
    rd(A_MSET, d);          check(d == 32'hFFFF_FFFF, "R3 mask w0", d, 32'hFFFF_FFFF);
    rd(A_MCLR + 12'd4, d);  check(d == 32'h0000_00FF, "R1 R3 mask w1", d, 32'h0000_00FF);
    rd(A_SSET, d);          check(d == 32'h0, "R3 sens w0", d, 32'h0);
    rd(A_PCLR, d);          check(d == 32'hFFFF_FFFF, "R3 pol w0", d, 32'hFFFF_FFFF);
    rd(A_ACK + 12'd4, d);   check(d == 32'h0, "R3 status w1", d, 32'h0);
    rd(A_CTRL, d);          check(d == 32'h0, "R3 ctrl", d, 32'h0);
    check(irq_q == '0, "R3 irq idle", 32'(irq_q), 32'h0);

    // R2 write-one semantics
    wr(A_MCLR, 32'h0);      rd(A_MSET, d); check(d == 32'hFFFF_FFFF, "R2 zero write", d, 32'hFFFF_FFFF);
    wr(A_MCLR, 32'h5);      rd(A_MSET, d); check(d == 32'hFFFF_FFFA, "R2 clr bits", d, 32'hFFFF_FFFA);
    rd(A_MCLR, d);          check(d == 32'hFFFF_FFFA, "R2 read clr addr", d, 32'hFFFF_FFFA);
    wr(A_MSET, 32'h5);      rd(A_MCLR, d); check(d == 32'hFFFF_FFFF, "R2 set bits", d, 32'hFFFF_FFFF);

    // R11 control readback
    wr(A_CTRL, 32'h3);      rd(A_CTRL, d); check(d == 32'h3, "R11 ctrl rb", d, 32'h3);
    wr(A_CTRL, 32'h0);

    // vector table: R4 R5 R6 R7 (enable clear, all lines masked)
    for (int i = 0; i < NV; i++) begin
      logic [11:0] e;
      int ln;
      e  = VEC[i];
      ln = int'(e[11:6]);
      if (e[5]) wr(A_SSET + wofs(ln), bitw(ln)); else wr(A_SCLR + wofs(ln), bitw(ln));
      if (e[4]) wr(A_PSET + wofs(ln), bitw(ln)); else wr(A_PCLR + wofs(ln), bitw(ln));
      wr(A_CTRL, {30'd0, e[3], 1'b0});
      irq_d[ln] = e[2];
      repeat (5) @(negedge clk);
      wr(A_ACK + wofs(ln), bitw(ln));
      irq_d[ln] = e[1];
      repeat (5) @(negedge clk);
      rd(A_ACK + wofs(ln), d);
      check(d[ln % 32] == e[0], $sformatf("R4 R5 R6 R7 vec %0d", i), {31'd0, d[ln % 32]}, {31'd0, e[0]});
    end

    // clean state
    irq_d = '0;
    wr(A_CTRL, 32'h0);
    wr(A_SCLR, 32'hFFFF_FFFF); wr(A_SCLR + 12'd4, 32'hFF);
    wr(A_PSET, 32'hFFFF_FFFF); wr(A_PSET + 12'd4, 32'hFF);
    repeat (5) @(negedge clk);
    ack_all();

    // R4 latency through synchronizer
    irq_d[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(A_ACK, d); check(d[2] == 1'b0, "R4 not before third edge", d, 32'h0);
    @(negedge clk);
    rd(A_ACK, d); check(d[2] == 1'b1, "R4 on third edge", d, 32'h4);
    irq_d[2] = 1'b0;
    repeat (4) @(negedge clk);
    ack_all();

    // R9 flush: line 2 active-high, line 34 active-low, line 7 masked
    wr(A_PCLR + 12'd4, 32'h4);
    irq_d[34] = 1'b1;
    wr(A_MCLR, 32'h4); wr(A_MCLR + 12'd4, 32'h4);
    repeat (5) @(negedge clk);
    ack_all();
    irq_d[2] = 1'b1; irq_d[7] = 1'b1; irq_d[34] = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_ACK, d);          check(d == 32'h84, "R6 masked and unmasked record", d, 32'h84);
    rd(A_ACK + 12'd4, d);  check(d == 32'h4, "R1 line34 in word1", d, 32'h4);
    wr(A_CTRL, 32'h5);
    check(irq_q[2] == 1'b1 && irq_q[34] == 1'b0 && irq_q[7] == 1'b0, "R9 pulse",
          {29'd0, irq_q[34], irq_q[7], irq_q[2]}, 32'h1);
    @(negedge clk);
    check(irq_q[2] == 1'b0 && irq_q[34] == 1'b1 && irq_q[7] == 1'b0, "R9 one cycle",
          {29'd0, irq_q[34], irq_q[7], irq_q[2]}, 32'h4);
    rd(A_ACK, d);          check(d == 32'h80, "R9 status after flush w0", d, 32'h80);
    rd(A_ACK + 12'd4, d);  check(d == 32'h0, "R9 status after flush w1", d, 32'h0);
    rd(A_CTRL, d);         check(d == 32'h1, "R10 flush reads 0", d, 32'h1);

    // R10 flush without enable
    irq_d[2] = 1'b0;
    repeat (4) @(negedge clk);
    irq_d[2] = 1'b1;
    repeat (4) @(negedge clk);
    wr(A_CTRL, 32'h4);
    check(irq_q[2] == 1'b0, "R10 no pulse", {31'd0, irq_q[2]}, 32'h0);
    rd(A_ACK, d);          check(d == 32'h84, "R10 status kept", d, 32'h84);
    rd(A_CTRL, d);         check(d == 32'h0, "R10 ctrl", d, 32'h0);

    // R8 acknowledge
    wr(A_ACK, 32'h4);
    rd(A_ACK, d);          check(d == 32'h80, "R8 ack line2 only", d, 32'h80);
    wr(A_ACK, 32'h0);
    rd(A_ACK, d);          check(d == 32'h80, "R8 zero ack", d, 32'h80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule